// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-State Sequencer

This block sits on the controller side of a single-rank SDR SDRAM. It owns the clock-enable pin and the command bus while the device moves into and out of its low-power states. It tracks four states: idle with all banks closed, power-down, self-refresh, and clock-suspend during a burst. Every transition is a combination of the clock-enable level on the previous edge, the level on the current edge, and the command sent on the current edge. The block only drives the combinations the device defines.

A host raises single-cycle requests to enter or leave power-down, enter or leave self-refresh, and suspend or resume a running burst. It also supplies two qualifiers: all banks idle, and burst active. When the block is idle and ready, it registers the host command onto the bus. At all other times it drives the commands itself. After any exit, a down-counter keeps the ready flag low until the device can take ordinary commands again. A second counter enforces a minimum time with clock-enable low. The cycle counts are parameters: `T_PD_MIN` (minimum low time), `T_CKS` (power-down exit guard) and `T_XSR` (self-refresh exit period, at least 2).

Top module: `sdram_cke_seq`

## Requirements
- R1: During reset, cke_o is 1, cmd_o is NOP (4'b0111, bits {cs_n,ras_n,cas_n,we_n}), state_o is idle (2'd0), ready_o is 1 and req_err_o is 0.
- R2: While state_o is idle and ready_o is 1, with no request accepted, cmd_o on the next edge equals host_cmd_i and cke_o stays 1.
- R3: A valid power-down entry makes cke_o 0, cmd_o NOP and state_o power-down (2'd1) on the edge that samples the request, and ready_o drops.
- R4: A valid self-refresh entry makes cke_o 0, cmd_o AUTO REFRESH (4'b0001) and state_o self-refresh (2'd2) on the sampling edge.
- R5: With burst_active_i at 1, a suspend request makes cke_o 0 and state_o suspend (2'd3). A resume request makes cke_o 1 with NOP and state_o idle, and ready_o returns one edge later.
- R6: While state_o is not idle, cke_o is 0 and cmd_o is NOP regardless of host_cmd_i.
- R7: In power-down and self-refresh, cke_o stays low for at least T_PD_MIN edges. An exit request that comes earlier is held and carried out on the edge T_PD_MIN after entry.
- R8: A power-down exit drives cke_o 1 with NOP. ready_o returns T_CKS edges later, and cmd_o is NOP until then.
- R9: A self-refresh exit drives cke_o 1 with NOP. cmd_o stays NOP for max(T_XSR,2) edges, which is at least two NOPs, and then ready_o returns.
- R10: A request that is invalid in the current state, or two requests at once, gives a one-cycle req_err_o pulse on the sampling edge and leaves state_o unchanged.
- R11: Power-down and self-refresh entry are accepted only when idle, ready, banks_idle_i is 1 and burst_active_i is 0. Otherwise they are errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| banks_idle_i | input | 1 | Host reports all banks precharged |
| burst_active_i | input | 1 | Host reports a read or write burst in flight |
| pd_enter_i | input | 1 | Request power-down entry |
| pd_exit_i | input | 1 | Request power-down exit |
| sr_enter_i | input | 1 | Request self-refresh entry |
| sr_exit_i | input | 1 | Request self-refresh exit |
| susp_enter_i | input | 1 | Request clock-suspend |
| susp_exit_i | input | 1 | Request resume from clock-suspend |
| host_cmd_i | input | 4 | Host command {cs_n,ras_n,cas_n,we_n} |
| cke_o | output | 1 | Registered clock-enable to device |
| cmd_o | output | 4 | Registered command to device |
| state_o | output | 2 | Power state: 0 idle, 1 power-down, 2 self-refresh, 3 suspend |
| ready_o | output | 1 | Device accepts ordinary commands |
| req_err_o | output | 1 | One-cycle pulse on an invalid request |

## Verification
Entry effects, errors and passed-through host commands appear on the edge that samples the request. The bench therefore drives a request one nanosecond after an edge and reads the result one nanosecond after the next edge. Exit timing is swept for both low-power states: the exit request is delayed by 0 to 5 edges, and the bench counts edges until cke_o rises, expecting max(T_PD_MIN, delay+1). From the exit edge it then counts NOP edges until ready_o, expecting T_CKS or max(T_XSR,2) exactly. Resume from suspend is expected to restore ready_o exactly one edge after the exit edge.

// File: rtl/sdram_cke_pkg.sv
`timescale 1ns/1ps
package sdram_cke_pkg;
  localparam int CMD_W = 4;
  localparam int NREQ  = 6;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_PDN  = 2'd1,
    PS_SREF = 2'd2,
    PS_SUSP = 2'd3
  } pwr_state_e;

  // values equal request index + 1
  typedef enum logic [2:0] {
    ACT_NONE   = 3'd0,
    ACT_PD_IN  = 3'd1,
    ACT_SR_IN  = 3'd2,
    ACT_SU_IN  = 3'd3,
    ACT_PD_OUT = 3'd4,
    ACT_SR_OUT = 3'd5,
    ACT_SU_OUT = 3'd6
  } act_e;

  localparam logic [CMD_W-1:0] CMD_NOP  = 4'b0111;
  localparam logic [CMD_W-1:0] CMD_AREF = 4'b0001;
endpackage

// File: rtl/sdram_cke_req.sv
`timescale 1ns/1ps
module sdram_cke_req
  import sdram_cke_pkg::*;
(
  input  pwr_state_e      state_i,
  input  logic            ready_i,
  input  logic            banks_idle_i,
  input  logic            burst_i,
  input  logic [NREQ-1:0] req_i,
  output act_e            act_o,
  output logic            err_o
);
  logic [NREQ-1:0] valid;
  logic            idle_rdy;
  logic            multi;

  assign idle_rdy = (state_i == PS_IDLE) && ready_i;

  always_comb begin
    valid[0] = idle_rdy && banks_idle_i && !burst_i;
    valid[1] = idle_rdy && banks_idle_i && !burst_i;
    valid[2] = idle_rdy && burst_i;
    valid[3] = (state_i == PS_PDN);
    valid[4] = (state_i == PS_SREF);
    valid[5] = (state_i == PS_SUSP);
  end

  assign multi = ($countones(req_i) > 1);
  assign err_o = multi || (|(req_i & ~valid));

  always_comb begin
    act_o = ACT_NONE;
    if (!err_o) begin
      for (int i = 0; i < NREQ; i++) begin
        if (req_i[i]) act_o = act_e'(3'(i + 1));
      end
    end
  end
endmodule

// File: rtl/sdram_cke_timer.sv
`timescale 1ns/1ps
module sdram_cke_timer #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdram_cke_fsm.sv
`timescale 1ns/1ps
module sdram_cke_fsm
  import sdram_cke_pkg::*;
#(
  parameter int RES_W   = 2,
  parameter int REC_W   = 3,
  parameter int RES_VAL = 2,
  parameter int PDX_VAL = 1,
  parameter int SRX_VAL = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  act_e             act_i,
  input  logic             err_i,
  input  logic             ready_i,
  input  logic             res_zero_i,
  input  logic [CMD_W-1:0] host_cmd_i,
  output pwr_state_e       state_o,
  output logic             cke_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic             err_o,
  output logic             res_load_o,
  output logic [RES_W-1:0] res_val_o,
  output logic             rec_load_o,
  output logic [REC_W-1:0] rec_val_o
);
  pwr_state_e       state_q, state_d;
  logic             pend_q, pend_d;
  logic             cke_q, cke_d;
  logic [CMD_W-1:0] cmd_q, cmd_d;
  logic             err_q;
  logic             exit_hit;

  assign exit_hit  = (act_i == ACT_PD_OUT) || (act_i == ACT_SR_OUT);
  assign res_val_o = RES_W'(RES_VAL);

  always_comb begin
    state_d    = state_q;
    pend_d     = pend_q;
    cke_d      = cke_q;
    cmd_d      = CMD_NOP;
    res_load_o = 1'b0;
    rec_load_o = 1'b0;
    rec_val_o  = REC_W'(PDX_VAL);
    unique case (state_q)
      PS_IDLE: begin
        cke_d  = 1'b1;
        pend_d = 1'b0;
        case (act_i)
          ACT_PD_IN: begin
            state_d    = PS_PDN;
            cke_d      = 1'b0;
            res_load_o = 1'b1;
          end
          ACT_SR_IN: begin
            state_d    = PS_SREF;
            cke_d      = 1'b0;
            cmd_d      = CMD_AREF;
            res_load_o = 1'b1;
          end
          ACT_SU_IN: begin
            state_d = PS_SUSP;
            cke_d   = 1'b0;
          end
          default: if (ready_i) cmd_d = host_cmd_i;
        endcase
      end
      PS_PDN, PS_SREF: begin
        cke_d = 1'b0;
        if ((pend_q || exit_hit) && res_zero_i) begin
          state_d    = PS_IDLE;
          cke_d      = 1'b1;
          pend_d     = 1'b0;
          rec_load_o = 1'b1;
          rec_val_o  = (state_q == PS_SREF) ? REC_W'(SRX_VAL) : REC_W'(PDX_VAL);
        end else if (exit_hit) begin
          pend_d = 1'b1;  // early exit: hold until residency met
        end
      end
      PS_SUSP: begin
        cke_d = 1'b0;
        if (act_i == ACT_SU_OUT) begin
          state_d    = PS_IDLE;
          cke_d      = 1'b1;
          rec_load_o = 1'b1;
          rec_val_o  = REC_W'(1);
        end
      end
      default: state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_IDLE;
      pend_q  <= 1'b0;
      cke_q   <= 1'b1;
      cmd_q   <= CMD_NOP;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      cke_q   <= cke_d;
      cmd_q   <= cmd_d;
      err_q   <= err_i;
    end
  end

  assign state_o = state_q;
  assign cke_o   = cke_q;
  assign cmd_o   = cmd_q;
  assign err_o   = err_q;
endmodule

// File: rtl/sdram_cke_seq.sv
`timescale 1ns/1ps
module sdram_cke_seq
  import sdram_cke_pkg::*;
#(
  parameter int T_PD_MIN = 3,
  parameter int T_CKS    = 1,
  parameter int T_XSR    = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       banks_idle_i,
  input  logic       burst_active_i,
  input  logic       pd_enter_i,
  input  logic       pd_exit_i,
  input  logic       sr_enter_i,
  input  logic       sr_exit_i,
  input  logic       susp_enter_i,
  input  logic       susp_exit_i,
  input  logic [3:0] host_cmd_i,
  output logic       cke_o,
  output logic [3:0] cmd_o,
  output logic [1:0] state_o,
  output logic       ready_o,
  output logic       req_err_o
);
  localparam int P_EFF   = (T_PD_MIN < 1) ? 1 : T_PD_MIN;
  localparam int CKS_EFF = (T_CKS < 1) ? 1 : T_CKS;
  localparam int XSR_EFF = (T_XSR < 2) ? 2 : T_XSR;
  localparam int REC_MAX = (CKS_EFF > XSR_EFF) ? CKS_EFF : XSR_EFF;
  localparam int RES_W   = $clog2(P_EFF + 1);
  localparam int REC_W   = $clog2(REC_MAX + 1);

  pwr_state_e       state;
  act_e             act;
  logic             dec_err;
  logic [NREQ-1:0]  req;
  logic             res_load, rec_load, res_zero, rec_zero;
  logic [RES_W-1:0] res_val;
  logic [REC_W-1:0] rec_val;

  assign req = {susp_exit_i, sr_exit_i, pd_exit_i, susp_enter_i, sr_enter_i, pd_enter_i};
  assign ready_o = (state == PS_IDLE) && rec_zero;
  assign state_o = state;

  sdram_cke_req i_req (
    .state_i      (state),
    .ready_i      (ready_o),
    .banks_idle_i (banks_idle_i),
    .burst_i      (burst_active_i),
    .req_i        (req),
    .act_o        (act),
    .err_o        (dec_err)
  );

  sdram_cke_fsm #(
    .RES_W   (RES_W),
    .REC_W   (REC_W),
    .RES_VAL (P_EFF - 1),
    .PDX_VAL (CKS_EFF),
    .SRX_VAL (XSR_EFF)
  ) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (act),
    .err_i      (dec_err),
    .ready_i    (ready_o),
    .res_zero_i (res_zero),
    .host_cmd_i (host_cmd_i),
    .state_o    (state),
    .cke_o      (cke_o),
    .cmd_o      (cmd_o),
    .err_o      (req_err_o),
    .res_load_o (res_load),
    .res_val_o  (res_val),
    .rec_load_o (rec_load),
    .rec_val_o  (rec_val)
  );

  // residency timer
  sdram_cke_timer #(.W(RES_W)) i_res_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (res_load),
    .val_i  (res_val),
    .zero_o (res_zero)
  );

  // exit recovery timer
  sdram_cke_timer #(.W(REC_W)) i_rec_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (rec_load),
    .val_i  (rec_val),
    .zero_o (rec_zero)
  );
endmodule

// File: rtl/sdram_cke_chk.sv
`timescale 1ns/1ps
module sdram_cke_chk
  import sdram_cke_pkg::*;
#(
  parameter int T_PD_MIN = 3,
  parameter int T_XSR    = 8
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       banks_idle_i,
  input logic       cke_o,
  input logic [3:0] cmd_o,
  input logic [1:0] state_o,
  input logic       ready_o,
  input logic       req_err_o
);
  localparam int P_EFF   = (T_PD_MIN < 1) ? 1 : T_PD_MIN;
  localparam int XSR_EFF = (T_XSR < 2) ? 2 : T_XSR;

  logic [15:0] low_cnt;
  logic [15:0] sr_cnt;
  logic        sr_flag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt <= '0;
      sr_cnt  <= '0;
      sr_flag <= 1'b0;
    end else begin
      if (cke_o)                low_cnt <= '0;
      else if (low_cnt != '1)   low_cnt <= low_cnt + 1'b1;
      if (state_o == PS_SREF) begin
        sr_cnt  <= '0;
        sr_flag <= 1'b1;
      end else if (ready_o) begin
        sr_flag <= 1'b0;
      end else if (sr_flag && sr_cnt != '1) begin
        sr_cnt <= sr_cnt + 1'b1;
      end
    end
  end

  AST_LP_CKE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != PS_IDLE |-> !cke_o); // R6

  AST_SR_ENTRY_AREF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == PS_SREF && $past(state_o) == PS_IDLE) |-> cmd_o == CMD_AREF); // R4

  AST_ENTRY_BANKS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cke_o) && state_o != PS_SUSP) |-> $past(banks_idle_i)); // R11

  AST_RECOVER_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == PS_IDLE && !ready_o) |-> cmd_o == CMD_NOP); // R8

  AST_ERR_HOLDS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_err_o |-> state_o == $past(state_o)); // R10

  AST_MIN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cke_o) && $past(state_o) != PS_SUSP) |-> low_cnt >= 16'(P_EFF)); // R7

  AST_SR_XSR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ready_o) && sr_flag) |-> sr_cnt >= 16'(XSR_EFF)); // R9
endmodule

bind sdram_cke_seq sdram_cke_chk #(
  .T_PD_MIN (T_PD_MIN),
  .T_XSR    (T_XSR)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .banks_idle_i (banks_idle_i),
  .cke_o        (cke_o),
  .cmd_o        (cmd_o),
  .state_o      (state_o),
  .ready_o      (ready_o),
  .req_err_o    (req_err_o)
);

// File: tb/test_sdram_cke_seq.sv
`timescale 1ns/1ps
module test_sdram_cke_seq;
  localparam int P   = 3;
  localparam int CKS = 2;
  localparam int XSR = 5;
  localparam logic [3:0] NOP  = 4'b0111;
  localparam logic [3:0] AREF = 4'b0001;
  localparam logic [3:0] WR   = 4'b0100;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       banks_idle_i, burst_active_i;
  logic       pd_enter_i, pd_exit_i, sr_enter_i, sr_exit_i, susp_enter_i, susp_exit_i;
  logic [3:0] host_cmd_i;
  logic       cke_o, ready_o, req_err_o;
  logic [3:0] cmd_o;
  logic [1:0] state_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #4 clk_i = ~clk_i;

  sdram_cke_seq #(.T_PD_MIN(P), .T_CKS(CKS), .T_XSR(XSR)) i_sdram_cke_seq (
    .clk_i, .rst_ni, .banks_idle_i, .burst_active_i,
    .pd_enter_i, .pd_exit_i, .sr_enter_i, .sr_exit_i, .susp_enter_i, .susp_exit_i,
    .host_cmd_i, .cke_o, .cmd_o, .state_o, .ready_o, .req_err_o
  );

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic clr_req();
    pd_enter_i = 0; pd_exit_i = 0; sr_enter_i = 0;
    sr_exit_i = 0; susp_enter_i = 0; susp_exit_i = 0;
  endtask

  // enter PD or SR, delay exit by d edges, measure exit and recovery
  task automatic lp_cycle(input bit is_sr, input int d);
    int el;
    int r;
    int exp_el;
    int exp_r;
    host_cmd_i = WR;
    if (is_sr) sr_enter_i = 1; else pd_enter_i = 1;
    tick(); clr_req();
    chk(is_sr ? "R4 state" : "R3 state", state_o, is_sr ? 2 : 1);
    chk(is_sr ? "R4 cke" : "R3 cke", cke_o, 0);
    chk(is_sr ? "R4 cmd" : "R3 cmd", cmd_o, is_sr ? AREF : NOP);
    chk("R3 ready low", ready_o, 0);
    el = 0;
    repeat (d) begin
      tick(); el++;
      chk("R6 hold cke", cke_o, 0);
      chk("R6 hold cmd", cmd_o, NOP);
    end
    if (is_sr) sr_exit_i = 1; else pd_exit_i = 1;
    tick(); el++; clr_req();
    while (cke_o == 0 && el < 40) begin
      chk("R6 pending cmd", cmd_o, NOP);
      tick(); el++;
    end
    exp_el = (d + 1 > P) ? d + 1 : P;
    chk("R7 low edges", el, exp_el);
    chk(is_sr ? "R9 exit state" : "R8 exit state", state_o, 0);
    r = 0;
    while (!ready_o && r < 40) begin
      chk(is_sr ? "R9 nop" : "R8 nop", cmd_o, NOP);
      tick(); r++;
    end
    exp_r = is_sr ? XSR : CKS;
    chk(is_sr ? "R9 recovery" : "R8 recovery", r, exp_r);
    tick();
    chk("R2 resume passthrough", cmd_o, WR);
  endtask

  task automatic wait_ready();
    int k = 0;
    while (!ready_o && k < 40) begin tick(); k++; end
  endtask

  initial begin
    rst_ni = 0; banks_idle_i = 1; burst_active_i = 0; host_cmd_i = NOP;
    clr_req();
    #10;
    chk("R1 cke", cke_o, 1);
    chk("R1 cmd", cmd_o, NOP);
    chk("R1 state", state_o, 0);
    chk("R1 ready", ready_o, 1);
    chk("R1 err", req_err_o, 0);
    #7 rst_ni = 1;
    tick(); tick();

    for (int c = 0; c < 16; c++) begin
      host_cmd_i = 4'(c);
      tick();
      chk("R2 cmd", cmd_o, c);
      chk("R2 cke", cke_o, 1);
    end

    for (int d = 0; d < 6; d++) lp_cycle(1'b0, d);
    for (int d = 0; d < 6; d++) lp_cycle(1'b1, d);

    // suspend / resume
    burst_active_i = 1; host_cmd_i = WR;
    pd_enter_i = 1; tick(); clr_req();
    chk("R11 pd during burst err", req_err_o, 1);
    chk("R11 pd during burst cke", cke_o, 1);
    susp_enter_i = 1; tick(); clr_req();
    chk("R5 susp state", state_o, 3);
    chk("R5 susp cke", cke_o, 0);
    chk("R5 susp ready", ready_o, 0);
    repeat (3) begin
      tick();
      chk("R6 susp cmd", cmd_o, NOP);
      chk("R6 susp cke", cke_o, 0);
    end
    susp_exit_i = 1; tick(); clr_req();
    chk("R5 resume cke", cke_o, 1);
    chk("R5 resume cmd", cmd_o, NOP);
    chk("R5 resume state", state_o, 0);
    chk("R5 resume ready low", ready_o, 0);
    tick();
    chk("R5 ready next edge", ready_o, 1);
    tick();
    chk("R5 cmd accepted", cmd_o, WR);
    burst_active_i = 0;

    // errors
    banks_idle_i = 0; pd_enter_i = 1; tick(); clr_req();
    chk("R11 banks busy err", req_err_o, 1);
    chk("R11 banks busy state", state_o, 0);
    chk("R11 banks busy cke", cke_o, 1);
    tick();
    chk("R10 err one cycle", req_err_o, 0);
    banks_idle_i = 1;
    susp_enter_i = 1; tick(); clr_req();
    chk("R10 susp no burst", req_err_o, 1);
    chk("R10 susp no burst state", state_o, 0);
    pd_exit_i = 1; tick(); clr_req();
    chk("R10 exit in idle", req_err_o, 1);
    pd_enter_i = 1; sr_enter_i = 1; tick(); clr_req();
    chk("R10 double req err", req_err_o, 1);
    chk("R10 double req state", state_o, 0);
    chk("R10 double req cke", cke_o, 1);

    pd_enter_i = 1; tick(); clr_req();
    repeat (P - 1) tick();
    pd_exit_i = 1; tick(); clr_req();
    chk("R8 exit at residency", cke_o, 1);
    pd_enter_i = 1; tick(); clr_req();
    chk("R11 entry while recovering", req_err_o, 1);
    chk("R11 entry while recovering state", state_o, 0);
    wait_ready();

    pd_enter_i = 1; tick(); clr_req();
    sr_exit_i = 1; tick(); clr_req();
    chk("R10 wrong exit err", req_err_o, 1);
    chk("R10 wrong exit state", state_o, 1);
    chk("R10 wrong exit cke", cke_o, 0);
    pd_exit_i = 1; tick(); clr_req();
    wait_ready();
    chk("R8 back to idle", state_o, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule